// File: doc/BRIEF.md
# Oscillator Tap Trimming Loop

This block keeps a ring-type digitally controlled oscillator on frequency by comparing it, window after window, with a slow reference clock (a 32768 Hz watch-crystal tick in the intended system). It runs entirely on the oscillator's own clock. Rising edges of the reference pass through a two-flop synchronizer, and the number of oscillator cycles between window boundaries is counted and compared with a programmed target count. After every window a combined 10-bit trim word moves one step toward the target. The upper five bits of the word choose one of 32 oscillator taps, each roughly three percent apart. The lower five bits give a fractional part that dithers the oscillator between the chosen tap and the next one up.

A coarse band-select value is passed straight through to the oscillator and is never touched by the loop. Software can leave the loop enabled, so that it keeps re-measuring and correcting drift, or pulse the enable for a single retrim. While the loop is disabled the trim word is frozen. A lock flag reports when the measured count has stayed close to the target for two windows in a row.

The control sequence is a four-state machine. HOLD means the loop is disabled. ARM waits for the first reference boundary, which only opens a window. MEASURE counts the window. TRIM lasts one cycle and applies the step and the lock decision. Transitions: HOLD to ARM when enable is high. ARM to MEASURE once the meter has seen its opening boundary. MEASURE to TRIM when a window result arrives. TRIM back to MEASURE unconditionally. Any state goes to HOLD when enable is low.

Top module: `fll_tap_ctrl`

## Requirements
- R1: After reset, tap_code is 16, mod_code is 0, osc_tap is 16 and lock is 0.
- R2: range_out always equals range_sel, independent of enable and of the loop state.
- R3: With a constant trim word, any 32 consecutive cycles of osc_tap show tap_code+1 exactly mod_code times and tap_code the rest of the time. When tap_code is 31, osc_tap stays at 31.
- R4: The trim word is {tap_code, mod_code}, with tap_code in bits 9..5 and mod_code in bits 4..0. After each measured window it rises by one if the count (the oscillator cycles between window boundaries) is below target_cnt, falls by one if it is above, and is unchanged if it is equal.
- R5: The trim word saturates at 0 and at 1023 and never wraps.
- R6: While enable is low the trim word holds its value and lock reads 0. After enable rises again, the first reference boundary only opens a window and causes no trim step.
- R7: lock becomes 1 after two consecutive windows whose absolute count error is at most tol. It returns to 0 after any window with a larger error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference clock, asynchronous to osc_clk |
| enable | input | 1 | Loop enable; low freezes the trim word |
| target_cnt | input | 12 | Expected oscillator cycles per window |
| tol | input | 6 | Lock tolerance on the absolute count error |
| range_sel | input | 3 | Coarse band request |
| range_out | output | 3 | Band value forwarded to the oscillator |
| osc_tap | output | 5 | Dithered tap applied to the oscillator each cycle |
| tap_code | output | 5 | Integer tap part of the trim word |
| mod_code | output | 5 | Fractional part of the trim word |
| lock | output | 1 | Count has stayed within tolerance for two windows |

## Verification
A reference rising edge first seen at oscillator edge k becomes a window boundary pulse two cycles later. The count is registered at edge k+2, the state machine enters TRIM at k+3, and the trim word and lock change at edge k+4. The scoreboard stamps each expected word and lock value with a due cycle six cycles after the rising edge is driven. It compares them on a falling edge at that point, before the next boundary can arrive, because every driven reference period is at least 20 cycles. The dither pattern is observed over 32 consecutive falling edges only after the loop has been held off for 40 cycles. This guarantees a steady trim word during the count.

// File: rtl/fll_pkg.sv
package fll_pkg;
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_ARM     = 2'd1,
        ST_MEASURE = 2'd2,
        ST_TRIM    = 2'd3
    } fll_state_e;
endpackage

// File: rtl/fll_ref_sync.sv
module fll_ref_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic ref_rise
);
    // SYNC_STAGES flops for metastability plus one for edge detection
    logic [SYNC_STAGES:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[SYNC_STAGES-1:0], ref_in};
        end
    end

    assign ref_rise = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];
endmodule

// File: rtl/fll_window_meter.sv
module fll_window_meter #(
    parameter int CNT_W    = 12,
    parameter int WIN_REFS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ref_rise,
    output logic             armed,
    output logic             done,
    output logic [CNT_W-1:0] meas
);
    localparam int RC_W = (WIN_REFS > 1) ? $clog2(WIN_REFS) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;
    logic [RC_W-1:0]  ref_seen;
    logic             last_ref;

    assign last_ref = (ref_seen == RC_W'(WIN_REFS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            done     <= 1'b0;
            meas     <= '0;
            cnt      <= '0;
            ref_seen <= '0;
        end else begin
            done <= 1'b0;
            if (!run) begin
                armed    <= 1'b0;
                cnt      <= '0;
                ref_seen <= '0;
            end else if (ref_rise && !armed) begin
                armed    <= 1'b1;
                cnt      <= '0;
                ref_seen <= '0;
            end else if (ref_rise && last_ref) begin
                done     <= 1'b1;
                meas     <= (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;
                cnt      <= '0;
                ref_seen <= '0;
            end else begin
                if (ref_rise) begin
                    ref_seen <= ref_seen + 1'b1;
                end
                if (cnt != CNT_MAX) begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R4: a window result is only produced once a window has been opened
    p_result_after_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(armed));
endmodule

// File: rtl/fll_dither.sv
module fll_dither #(
    parameter int TAP_W = 5,
    parameter int MOD_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAP_W-1:0] tap,
    input  logic [MOD_W-1:0] frac,
    output logic [TAP_W-1:0] osc_tap
);
    localparam logic [TAP_W-1:0] TAP_TOP = '1;
    localparam logic [TAP_W-1:0] TAP_MID = TAP_W'(1) << (TAP_W - 1);

    logic [MOD_W-1:0] acc;
    logic [MOD_W:0]   acc_sum;
    logic             step_up;

    // phase accumulator: carries out frac times per 2**MOD_W cycles, evenly spaced
    assign acc_sum = {1'b0, acc} + {1'b0, frac};
    assign step_up = acc_sum[MOD_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc     <= '0;
            osc_tap <= TAP_MID;
        end else begin
            acc     <= acc_sum[MOD_W-1:0];
            osc_tap <= (step_up && tap != TAP_TOP) ? tap + 1'b1 : tap;
        end
    end

    // R3: applied tap is always the trimmed tap or its upper neighbour
    p_tap_neighbour_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, osc_tap} == {1'b0, $past(tap)}) ||
        ({1'b0, osc_tap} == {1'b0, $past(tap)} + 1'b1));
endmodule

// File: rtl/fll_trim_fsm.sv
module fll_trim_fsm
    import fll_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int TOL_W = 6,
    parameter int TAP_W = 5,
    parameter int MOD_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             armed,
    input  logic             done,
    input  logic [CNT_W-1:0] meas,
    input  logic [CNT_W-1:0] target,
    input  logic [TOL_W-1:0] tol,
    output logic [TAP_W-1:0] tap,
    output logic [MOD_W-1:0] frac,
    output logic             lock
);
    localparam int WORD_W = TAP_W + MOD_W;
    localparam logic [WORD_W-1:0] WORD_TOP   = '1;
    localparam logic [WORD_W-1:0] RESET_WORD = WORD_W'(1) << (WORD_W - 1);

    fll_state_e       state, state_nxt;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0] err_abs;
    logic             in_tol;
    logic             want_up, want_dn, win_ok, prev_ok;

    assign err_abs = (meas >= target) ? meas - target : target - meas;
    assign in_tol  = err_abs <= {{(CNT_W-TOL_W){1'b0}}, tol};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HOLD;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HOLD:    state_nxt = enable ? ST_ARM : ST_HOLD;
            ST_ARM:     state_nxt = armed ? ST_MEASURE : ST_ARM;
            ST_MEASURE: state_nxt = done ? ST_TRIM : ST_MEASURE;
            ST_TRIM:    state_nxt = ST_MEASURE;
        endcase
        if (!enable) begin
            state_nxt = ST_HOLD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word    <= RESET_WORD;
            lock    <= 1'b0;
            prev_ok <= 1'b0;
            want_up <= 1'b0;
            want_dn <= 1'b0;
            win_ok  <= 1'b0;
        end else begin
            unique case (state)
                ST_HOLD, ST_ARM: ;
                ST_MEASURE: begin
                    if (done) begin
                        want_up <= meas < target;
                        want_dn <= meas > target;
                        win_ok  <= in_tol;
                    end
                end
                ST_TRIM: begin
                    if (enable) begin
                        if (want_up && word != WORD_TOP) begin
                            word <= word + 1'b1;
                        end else if (want_dn && word != '0) begin
                            word <= word - 1'b1;
                        end
                        lock    <= win_ok && prev_ok;
                        prev_ok <= win_ok;
                    end
                end
            endcase
            if (!enable) begin
                lock    <= 1'b0;
                prev_ok <= 1'b0;
            end
        end
    end

    assign tap  = word[WORD_W-1:MOD_W];
    assign frac = word[MOD_W-1:0];

    // R4: the word moves by at most one step per update
    p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (word != $past(word)) |->
            ((word == $past(word) + 1'b1) || (word == $past(word) - 1'b1)));
    // R5: no wrap at either end
    p_no_wrap_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (word == WORD_TOP) |=> (word != '0));
    p_no_wrap_bottom_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (word == '0) |=> (word != WORD_TOP));
    // R6: frozen word and cleared lock while disabled
    p_hold_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(word));
    p_hold_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !lock);
    // R7: lock only rises out of a trim decision
    p_lock_from_trim_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> ($past(state) == ST_TRIM));
endmodule

// File: rtl/fll_tap_ctrl.sv
module fll_tap_ctrl #(
    parameter int CNT_W       = 12,
    parameter int TOL_W       = 6,
    parameter int RANGE_W     = 3,
    parameter int TAP_W       = 5,
    parameter int MOD_W       = 5,
    parameter int WIN_REFS    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic               osc_clk,
    input  logic               rst_n,
    input  logic               ref_tick,
    input  logic               enable,
    input  logic [CNT_W-1:0]   target_cnt,
    input  logic [TOL_W-1:0]   tol,
    input  logic [RANGE_W-1:0] range_sel,
    output logic [RANGE_W-1:0] range_out,
    output logic [TAP_W-1:0]   osc_tap,
    output logic [TAP_W-1:0]   tap_code,
    output logic [MOD_W-1:0]   mod_code,
    output logic               lock
);
    logic             ref_rise;
    logic             win_armed;
    logic             win_done;
    logic [CNT_W-1:0] win_count;

    assign range_out = range_sel;

    fll_ref_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (osc_clk),
        .rst_n    (rst_n),
        .ref_in   (ref_tick),
        .ref_rise (ref_rise)
    );

    fll_window_meter #(.CNT_W(CNT_W), .WIN_REFS(WIN_REFS)) u_meter (
        .clk      (osc_clk),
        .rst_n    (rst_n),
        .run      (enable),
        .ref_rise (ref_rise),
        .armed    (win_armed),
        .done     (win_done),
        .meas     (win_count)
    );

    fll_trim_fsm #(.CNT_W(CNT_W), .TOL_W(TOL_W), .TAP_W(TAP_W), .MOD_W(MOD_W)) u_fsm (
        .clk    (osc_clk),
        .rst_n  (rst_n),
        .enable (enable),
        .armed  (win_armed),
        .done   (win_done),
        .meas   (win_count),
        .target (target_cnt),
        .tol    (tol),
        .tap    (tap_code),
        .frac   (mod_code),
        .lock   (lock)
    );

    fll_dither #(.TAP_W(TAP_W), .MOD_W(MOD_W)) u_dither (
        .clk     (osc_clk),
        .rst_n   (rst_n),
        .tap     (tap_code),
        .frac    (mod_code),
        .osc_tap (osc_tap)
    );
endmodule

// File: tb/fll_tap_ctrl_bench.sv
`timescale 1ns/1ps
module fll_tap_ctrl_bench;
    localparam int CNT_W   = 12;
    localparam int TOL_W   = 6;
    localparam int RANGE_W = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ref_tick = 1'b0;
    logic               enable = 1'b0;
    logic [CNT_W-1:0]   target = 12'd200;
    logic [TOL_W-1:0]   tol = 6'd2;
    logic [RANGE_W-1:0] range_sel = '0;
    logic [RANGE_W-1:0] range_out;
    logic [4:0]         osc_tap, tap_code, mod_code;
    logic               lock;

    fll_tap_ctrl u_fll_tap_ctrl (
        .osc_clk    (clk),
        .rst_n      (rst_n),
        .ref_tick   (ref_tick),
        .enable     (enable),
        .target_cnt (target),
        .tol        (tol),
        .range_sel  (range_sel),
        .range_out  (range_out),
        .osc_tap    (osc_tap),
        .tap_code   (tap_code),
        .mod_code   (mod_code),
        .lock       (lock)
    );

    always #2 clk = ~clk;   // 250 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    due;
        int    word;
        bit    lk;
        string req;
    } item_t;
    item_t sb_q[$];

    int checks = 0;
    int fails  = 0;

    // reference model state
    int m_word = 512;
    bit m_lock = 0, m_prev = 0, m_armed = 0, m_en = 0;
    int last_rise = 0;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // monitor: pop expected results when they fall due
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            item_t it;
            int act_word;
            it = sb_q.pop_front();
            act_word = int'({tap_code, mod_code});
            check(act_word == it.word, it.req, act_word, it.word);
            check(lock == it.lk, "R7", int'(lock), int'(it.lk));
        end
    end

    // driver: one reference period of p oscillator cycles, with expectation
    task automatic ref_period(int p, string req);
        int now;
        item_t it;
        @(negedge clk);
        ref_tick = 1'b1;
        now = cyc;
        if (m_en) begin
            if (!m_armed) begin
                m_armed = 1;
            end else begin
                int meas;
                int err;
                bit ok;
                meas = now - last_rise;
                err  = (meas > int'(target)) ? meas - int'(target) : int'(target) - meas;
                ok   = err <= int'(tol);
                if (meas < int'(target) && m_word < 1023) m_word++;
                else if (meas > int'(target) && m_word > 0) m_word--;
                m_lock = ok && m_prev;
                m_prev = ok;
            end
        end
        last_rise = now;
        it.due = now + 6; it.word = m_word; it.lk = m_lock; it.req = req;
        sb_q.push_back(it);
        repeat (p / 2) @(negedge clk);
        ref_tick = 1'b0;
        repeat (p - p / 2 - 1) @(negedge clk);
    endtask

    task automatic loop_off();
        @(negedge clk);
        enable = 1'b0;
        m_en = 0; m_armed = 0; m_lock = 0; m_prev = 0;
    endtask

    task automatic loop_on();
        @(negedge clk);
        enable = 1'b1;
        m_en = 1;
    endtask

    // R3: count upper-neighbour cycles over 32 samples with the loop held
    task automatic dither_check();
        int hits = 0;
        int stray = 0;
        int tap = m_word >> 5;
        int frac = m_word & 31;
        int exp_hits = (tap == 31) ? 0 : frac;
        repeat (40) @(negedge clk);
        check(int'(tap_code) == tap, "R6", int'(tap_code), tap);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            if (tap != 31 && int'(osc_tap) == tap + 1) hits++;
            else if (int'(osc_tap) != tap) stray++;
        end
        check(hits == exp_hits, "R3", hits, exp_hits);
        check(stray == 0, "R3", stray, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(tap_code == 5'd16, "R1", int'(tap_code), 16);
        check(mod_code == 5'd0,  "R1", int'(mod_code), 0);
        check(osc_tap == 5'd16,  "R1", int'(osc_tap), 16);
        check(lock == 1'b0,      "R1", int'(lock), 0);
        // R2 band pass-through
        range_sel = 3'd5; #1;
        check(range_out == 3'd5, "R2", int'(range_out), 5);
        range_sel = 3'd2; #1;
        check(range_out == 3'd2, "R2", int'(range_out), 2);

        // R4 stepping up, down, holding; R7 lock gain and loss
        loop_on();
        for (int i = 0; i < 6; i++) ref_period(190, "R4");
        for (int i = 0; i < 3; i++) ref_period(205, "R4");
        for (int i = 0; i < 3; i++) ref_period(200, "R7");
        ref_period(202, "R7");
        ref_period(203, "R7");
        ref_period(200, "R7");

        // R6 hold while disabled, then dither on the frozen word
        loop_off();
        range_sel = 3'd6; #1;
        check(range_out == 3'd6, "R2", int'(range_out), 6);
        for (int i = 0; i < 3; i++) ref_period(150, "R6");
        dither_check();

        // R6 re-enable: first boundary only arms; R5 saturation at the top
        target = 12'd1000;
        loop_on();
        ref_period(20, "R6");
        for (int i = 0; i < 530; i++) ref_period(20, "R5");
        loop_off();
        dither_check();

        // R5 saturation at the bottom
        target = 12'd5;
        loop_on();
        for (int i = 0; i < 1045; i++) ref_period(20, "R5");
        loop_off();
        dither_check();

        repeat (20) @(negedge clk);
        check(sb_q.size() == 0, "R4", sb_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule